// File: doc/BRIEF.md
# USB Receive Endpoint Byte Counter

This block keeps the running byte count of the data packet that a USB receive endpoint is storing into its FIFO, so that a local microcontroller knows how many bytes to drain once the packet is handed over. The receiver pulses a strobe for each stored byte and brackets the packet with start and end markers. A good end-of-packet raises a packet-ready flag. The count is then frozen until firmware releases the packet.

A parameter picks the endpoint flavour. A control endpoint restarts its count when a SETUP packet arrives. A bulk/interrupt endpoint restarts it on an OUT token and freezes entirely while its direction bit selects transmit. Both flavours restart the count when firmware releases the packet or lifts a stall. Firmware reads the count through a byte-wide read port that decodes one fixed address: C9h for the control flavour and CAh for the other.

Top module: `usb_rx_byte_counter`

## Requirements
- R1: After the asynchronous reset (rst_ni low) or a cycle with bus_reset_i high, the count reads 0 and pkt_rdy_o and ovf_o are 0.
- R2: Each accepted byte strobe raises the count by one on the next clock edge, so a full packet leaves the count equal to max_pkt_i.
- R3: A byte strobe that arrives while the count already equals max_pkt_i leaves the count unchanged and sets ovf_o. Once set, ovf_o stays 1 until a reset of R1.
- R4: An accepted pkt_end_i sets pkt_rdy_o on the next edge. A short packet's count stays readable unchanged.
- R5: While pkt_rdy_o is 1, byte strobes, pkt_start_i and pkt_end_i change neither the count nor ovf_o.
- R6: A cycle with rdy_wr_i high and rdy_wdata_i = 1 clears the count and pkt_rdy_o. With rdy_wdata_i = 0 the write has no effect.
- R7: A cycle with stall_wr_i high and stall_wdata_i = 0 clears the count and pkt_rdy_o. With stall_wdata_i = 1 the write has no effect.
- R8: In control flavour, setup_tok_i clears the count and pkt_rdy_o, and out_tok_i has no effect.
- R9: In bulk/interrupt flavour, out_tok_i clears the count and pkt_rdy_o, and setup_tok_i has no effect.
- R10: In bulk/interrupt flavour with dir_tx_i = 1, byte strobes, pkt_start_i and pkt_end_i are ignored. The control flavour ignores dir_tx_i.
- R11: When a clear event of R6 to R9 and a byte strobe occur in the same cycle, the count ends at 0.
- R12: rd_data_o equals the count when rd_en_i is 1 and rd_addr_i equals C9h (control flavour) or CAh (bulk/interrupt flavour). Otherwise rd_data_o is 0.
- R13: An accepted pkt_start_i sets the count to 0 and drops any strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| bus_reset_i | input | 1 | USB bus reset seen, synchronous |
| byte_vld_i | input | 1 | One data byte stored this cycle |
| pkt_start_i | input | 1 | Data packet begins |
| pkt_end_i | input | 1 | Good end of data packet |
| setup_tok_i | input | 1 | SETUP token for this endpoint |
| out_tok_i | input | 1 | OUT token for this endpoint |
| max_pkt_i | input | 8 | Programmed maximum packet size |
| rdy_wr_i | input | 1 | Firmware write to the packet-ready bit |
| rdy_wdata_i | input | 1 | Value written to the packet-ready bit |
| stall_wr_i | input | 1 | Firmware write to the stall bit |
| stall_wdata_i | input | 1 | Value written to the stall bit |
| dir_tx_i | input | 1 | Endpoint direction is transmit |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Read data |
| pkt_rdy_o | output | 1 | Packet ready for firmware |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Assertions check on every cycle that any clear event leaves the count at zero, that the count is frozen whenever no byte can be accepted, that counting stops at the maximum size, that a good end of packet raises ready, and that overflow is sticky. The bench scenarios are needed for properties that depend on the flavour and on what firmware sees. These are the SETUP versus OUT clear rules, the transmit-direction freeze, the address decode of each flavour, the no-effect writes of 0 to ready and 1 to stall, and the exact count a short or restarted packet leaves behind.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic {EP_CTRL = 1'b0, EP_DATA = 1'b1} ep_kind_e;

  localparam logic [7:0] ADDR_CTRL = 8'hC9;
  localparam logic [7:0] ADDR_DATA = 8'hCA;

  function automatic logic [7:0] rd_addr_of(ep_kind_e kind);
    return (kind == EP_CTRL) ? ADDR_CTRL : ADDR_DATA;
  endfunction
endpackage

// File: rtl/rxc_clear_ctl.sv
module rxc_clear_ctl
  import rxc_pkg::*;
#(
  parameter ep_kind_e EP_KIND = EP_CTRL
) (
  input  logic bus_reset_i,
  input  logic setup_tok_i,
  input  logic out_tok_i,
  input  logic rdy_wr_i,
  input  logic rdy_wdata_i,
  input  logic stall_wr_i,
  input  logic stall_wdata_i,
  input  logic dir_tx_i,
  input  logic rdy_i,
  output logic clr_o,
  output logic acc_o
);
  logic tok_clr;
  logic dir_block;

  generate
    if (EP_KIND == EP_CTRL) begin : g_ctrl
      assign tok_clr   = setup_tok_i;
      assign dir_block = 1'b0;
    end else begin : g_data
      assign tok_clr   = out_tok_i;
      assign dir_block = dir_tx_i;
    end
  endgenerate

  assign clr_o = bus_reset_i
               | (rdy_wr_i & rdy_wdata_i)
               | (stall_wr_i & ~stall_wdata_i)
               | tok_clr;

  assign acc_o = ~rdy_i & ~dir_block;
endmodule

// File: rtl/rxc_count_core.sv
module rxc_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_reset_i,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic             start_i,
  input  logic             byte_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             at_max;

  assign at_max = (cnt_q >= max_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (acc_i) begin
      if (start_i)                cnt_q <= '0;
      else if (byte_i && !at_max) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          ovf_q <= 1'b0;
    else if (bus_reset_i)                                 ovf_q <= 1'b0;
    else if (!clr_i && acc_i && !start_i && byte_i && at_max) ovf_q <= 1'b1;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R11
  AST_HOLD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !clr_i) |=> $stable(cnt_q)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i && byte_i && cnt_q <= max_i) |=> cnt_q <= $past(max_i)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !bus_reset_i) |=> ovf_q); // R3
endmodule

// File: rtl/rxc_ready_flag.sv
module rxc_ready_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic acc_i,
  input  logic end_i,
  output logic rdy_o
);
  logic rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdy_q <= 1'b0;
    else if (clr_i)          rdy_q <= 1'b0;
    else if (acc_i && end_i) rdy_q <= 1'b1;
  end

  assign rdy_o = rdy_q;

  AST_RDY_ON_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && end_i && !clr_i) |=> rdy_q); // R4
endmodule

// File: rtl/rxc_read_port.sv
module rxc_read_port #(
  parameter int         CNT_W  = 8,
  parameter int         ADDR_W = 8,
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-1:0]  rd_data_o
);
  assign rd_data_o = (rd_en_i && rd_addr_i == MY_ADDR) ? cnt_i : '0;
endmodule

// File: rtl/usb_rx_byte_counter.sv
module usb_rx_byte_counter
  import rxc_pkg::*;
#(
  parameter ep_kind_e EP_KIND = EP_CTRL,
  parameter int       CNT_W   = 8,
  parameter int       ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_reset_i,
  input  logic              byte_vld_i,
  input  logic              pkt_start_i,
  input  logic              pkt_end_i,
  input  logic              setup_tok_i,
  input  logic              out_tok_i,
  input  logic [CNT_W-1:0]  max_pkt_i,
  input  logic              rdy_wr_i,
  input  logic              rdy_wdata_i,
  input  logic              stall_wr_i,
  input  logic              stall_wdata_i,
  input  logic              dir_tx_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              pkt_rdy_o,
  output logic              ovf_o
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(rd_addr_of(EP_KIND));

  logic             clr;
  logic             acc;
  logic             rdy;
  logic [CNT_W-1:0] cnt;

  rxc_clear_ctl #(.EP_KIND(EP_KIND)) u_clear_ctl (
    .bus_reset_i  (bus_reset_i),
    .setup_tok_i  (setup_tok_i),
    .out_tok_i    (out_tok_i),
    .rdy_wr_i     (rdy_wr_i),
    .rdy_wdata_i  (rdy_wdata_i),
    .stall_wr_i   (stall_wr_i),
    .stall_wdata_i(stall_wdata_i),
    .dir_tx_i     (dir_tx_i),
    .rdy_i        (rdy),
    .clr_o        (clr),
    .acc_o        (acc)
  );

  rxc_count_core #(.CNT_W(CNT_W)) u_count_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_reset_i(bus_reset_i),
    .clr_i      (clr),
    .acc_i      (acc),
    .start_i    (pkt_start_i),
    .byte_i     (byte_vld_i),
    .max_i      (max_pkt_i),
    .cnt_o      (cnt),
    .ovf_o      (ovf_o)
  );

  rxc_ready_flag u_ready_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .acc_i (acc),
    .end_i (pkt_end_i),
    .rdy_o (rdy)
  );

  rxc_read_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .MY_ADDR(MY_ADDR)) u_read_port (
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .cnt_i    (cnt),
    .rd_data_o(rd_data_o)
  );

  assign pkt_rdy_o = rdy;

  AST_BUS_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (cnt == '0 && !pkt_rdy_o && !ovf_o)); // R1
endmodule

// File: tb/usb_rx_byte_counter_bench.sv
`timescale 1ns/1ps
module usb_rx_byte_counter_bench;
  import rxc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 0, byte_vld = 0, pkt_start = 0, pkt_end = 0;
  logic setup_tok = 0, out_tok = 0, rdy_wr = 0, rdy_wd = 0;
  logic stall_wr = 0, stall_wd = 0, dir_tx = 0, rd_en = 0;
  logic [7:0] max_pkt = 8'd8, rd_addr = 8'h00;
  logic [7:0] rd_a, rd_b;
  logic rdy_a, rdy_b, ovf_a, ovf_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usb_rx_byte_counter #(.EP_KIND(EP_CTRL)) u_usb_rx_byte_counter (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .byte_vld_i(byte_vld),
    .pkt_start_i(pkt_start), .pkt_end_i(pkt_end), .setup_tok_i(setup_tok),
    .out_tok_i(out_tok), .max_pkt_i(max_pkt), .rdy_wr_i(rdy_wr), .rdy_wdata_i(rdy_wd),
    .stall_wr_i(stall_wr), .stall_wdata_i(stall_wd), .dir_tx_i(dir_tx),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_a), .pkt_rdy_o(rdy_a), .ovf_o(ovf_a));

  usb_rx_byte_counter #(.EP_KIND(EP_DATA)) u_usb_rx_byte_counter_ep1 (
    .clk_i(clk), .rst_ni(rst_n), .bus_reset_i(bus_reset), .byte_vld_i(byte_vld),
    .pkt_start_i(pkt_start), .pkt_end_i(pkt_end), .setup_tok_i(setup_tok),
    .out_tok_i(out_tok), .max_pkt_i(max_pkt), .rdy_wr_i(rdy_wr), .rdy_wdata_i(rdy_wd),
    .stall_wr_i(stall_wr), .stall_wdata_i(stall_wd), .dir_tx_i(dir_tx),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_b), .pkt_rdy_o(rdy_b), .ovf_o(ovf_b));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reads both counts at mid-low phase; each must be invisible at the other address
  task automatic chk_cnt(string req, int ea, int eb);
    rd_en = 1; rd_addr = 8'hC9; #0.4;
    chk({req, " ctrl cnt"}, rd_a, ea);
    chk({req, " data@C9"}, rd_b, 0);
    rd_addr = 8'hCA; #0.4;
    chk({req, " data cnt"}, rd_b, eb);
    chk({req, " ctrl@CA"}, rd_a, 0);
    rd_en = 0; rd_addr = 8'h00;
  endtask

  task automatic chk_flags(string req, int ra, int rb, int oa, int ob);
    chk({req, " rdy ctrl"}, rdy_a, ra);
    chk({req, " rdy data"}, rdy_b, rb);
    chk({req, " ovf ctrl"}, ovf_a, oa);
    chk({req, " ovf data"}, ovf_b, ob);
  endtask

  task automatic cyc();
    @(negedge clk);
    bus_reset = 0; byte_vld = 0; pkt_start = 0; pkt_end = 0; setup_tok = 0;
    out_tok = 0; rdy_wr = 0; stall_wr = 0;
  endtask

  task automatic do_bus_reset(); bus_reset = 1; cyc(); endtask
  task automatic do_start();     pkt_start = 1; cyc(); endtask
  task automatic do_end();       pkt_end = 1; cyc(); endtask
  task automatic bytes(int n);
    for (int i = 0; i < n; i++) begin byte_vld = 1; cyc(); end
  endtask
  task automatic wr_rdy(logic v);   rdy_wr = 1; rdy_wd = v; cyc(); endtask
  task automatic wr_stall(logic v); stall_wr = 1; stall_wd = v; cyc(); endtask

  task automatic t_reset();
    chk_cnt("R1 hw reset", 0, 0);
    chk_flags("R1 hw reset", 0, 0, 0, 0);
  endtask

  task automatic t_full_packet();
    do_bus_reset(); max_pkt = 8;
    do_start(); bytes(8); do_end();
    chk_cnt("R2 full packet", 8, 8);
    chk_flags("R4 full end", 1, 1, 0, 0);
    bytes(3); do_start(); do_end();
    chk_cnt("R5 held while ready", 8, 8);
    chk_flags("R5 no ovf while ready", 1, 1, 0, 0);
    wr_rdy(1);
    chk_cnt("R6 release", 0, 0);
    chk_flags("R6 release", 0, 0, 0, 0);
  endtask

  task automatic t_short_packet();
    do_bus_reset(); max_pkt = 8;
    do_start(); bytes(5); do_end();
    chk_cnt("R4 short packet", 5, 5);
    wr_rdy(0);
    chk_cnt("R6 write0 no effect", 5, 5);
    chk_flags("R6 write0 no effect", 1, 1, 0, 0);
    wr_rdy(1);
  endtask

  task automatic t_overflow();
    do_bus_reset(); max_pkt = 4;
    do_start(); bytes(6);
    chk_cnt("R3 capped", 4, 4);
    chk_flags("R3 ovf set", 0, 0, 1, 1);
    wr_rdy(1); do_start();
    chk_flags("R3 ovf sticky", 0, 0, 1, 1);
    do_bus_reset();
    chk_flags("R1 bus reset clears ovf", 0, 0, 0, 0);
    max_pkt = 8;
  endtask

  task automatic t_stall();
    do_bus_reset();
    do_start(); bytes(3);
    wr_stall(1);
    chk_cnt("R7 stall write1 no effect", 3, 3);
    wr_stall(0);
    chk_cnt("R7 stall write0 clears", 0, 0);
  endtask

  task automatic t_tokens();
    do_bus_reset();
    do_start(); bytes(3);
    setup_tok = 1; cyc();
    chk_cnt("R8 setup clears ctrl, R9 data ignores", 0, 3);
    bytes(2);
    chk_cnt("R2 continue", 2, 5);
    out_tok = 1; cyc();
    chk_cnt("R9 out clears data, R8 ctrl ignores", 2, 0);
    do_end();
    setup_tok = 1; cyc();
    chk_flags("R8 setup clears ready", 0, 1, 0, 0);
    out_tok = 1; cyc();
    chk_flags("R9 out clears ready", 0, 0, 0, 0);
  endtask

  task automatic t_tx_dir();
    do_bus_reset(); dir_tx = 1;
    do_start(); bytes(3); do_end();
    chk_cnt("R10 tx freezes data", 3, 0);
    chk_flags("R10 tx no ready", 1, 0, 0, 0);
    dir_tx = 0;
    do_bus_reset();
  endtask

  task automatic t_clear_vs_byte();
    do_bus_reset();
    do_start(); bytes(2);
    byte_vld = 1; rdy_wr = 1; rdy_wd = 1; cyc();
    chk_cnt("R11 clear wins", 0, 0);
    byte_vld = 1; stall_wr = 1; stall_wd = 0; cyc();
    chk_cnt("R11 stall clear wins", 0, 0);
  endtask

  task automatic t_restart();
    do_bus_reset();
    do_start(); bytes(3);
    pkt_start = 1; byte_vld = 1; cyc();
    chk_cnt("R13 start drops byte", 0, 0);
    bytes(2);
    chk_cnt("R13 restart count", 2, 2);
  endtask

  task automatic t_decode();
    do_bus_reset();
    do_start(); bytes(4);
    rd_en = 0; rd_addr = 8'hC9; #0.4;
    chk("R12 no enable ctrl", rd_a, 0);
    rd_addr = 8'hCA; #0.4;
    chk("R12 no enable data", rd_b, 0);
    rd_en = 1; rd_addr = 8'hC8; #0.4;
    chk("R12 other addr ctrl", rd_a, 0);
    chk("R12 other addr data", rd_b, 0);
    rd_en = 0; rd_addr = 8'h00;
    chk_cnt("R12 hit", 4, 4);
    do_bus_reset();
    chk_cnt("R1 bus reset mid packet", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_packet();
    t_short_packet();
    t_overflow();
    t_stall();
    t_tokens();
    t_tx_dir();
    t_clear_vs_byte();
    t_restart();
    t_decode();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule